// File: doc/BRIEF.md
# Four-Wide Register Rename Table

This block is the rename stage of an out-of-order core. Each cycle it takes a group of up to four decoded instructions. For each one it looks up the physical tags of its two source registers. It takes a fresh physical tag from a free list for every destination, and it records the new tags in the architectural-to-physical map. An instruction may have a second destination. A load that also writes back its incremented base address gets one tag for the loaded value and another for the new base. Its base source is read through the mapping that held before it was renamed.

Instructions in one group can depend on each other. A source register written by an earlier slot of the same group therefore receives the tag that slot has just been given, not the stale table entry. For every destination the block also reports the physical tag that the destination replaces. The retire logic later hands these tags back through the return port, and they re-enter the free list. If the free list cannot cover all destinations of a group, the whole group stalls and no state changes.

All renamed outputs are combinational from the current inputs and state. A group counts as renamed in the cycle where `stall` is low, and its map updates take effect from the next clock edge.

Top module: `rename_map4`

## Requirements
- R1: A group of up to four valid slots is renamed in a single cycle whenever `stall` is low; its map writes and free-list pops are visible from the next cycle on.
- R2: A slot with `slot_has_upd` set gets a second new tag on `tag_upd`, and that tag differs from its `tag_dst`. The base register is the register named by `slot_src1`. The base source tag on `tag_src1` is the mapping of that register from before the slot's own writes.
- R3: Every destination write gets a newly allocated physical tag, so no two destinations of one renamed group share a tag, even when they name the same architectural register.
- R4: A source register that an earlier valid slot of the same group writes resolves to the tag allocated to the most recent such earlier write.
- R5: After reset, architectural register r maps to physical tag r. The free list holds tags ARCH up to PHYS-1 in ascending order, so the first allocated tag is ARCH.
- R6: Tags are taken from the free list in slot order 0 to 3. Within a slot the value destination (`slot_dst`) is taken before the base-update destination.
- R7: When several slots of a group write one architectural register, the map keeps the tag of the youngest write (highest slot, base update after value destination).
- R8: `stall` is high exactly when the total destination count of the valid slots exceeds the free-list count. A stalled group changes neither the map nor the free list.
- R9: Tags offered on the return port enter the free list at the tail in port order, even during a stall, and are handed out again in first-in first-out order.
- R10: For each allocated destination, `tag_prev_dst` / `tag_prev_upd` give the tag that the write displaces: the in-group mapping just before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | SLOTS | Slot i carries an instruction |
| slot_src1 | input | SLOTS*AW | First source register per slot (also the base register) |
| slot_src2 | input | SLOTS*AW | Second source register per slot |
| slot_dst | input | SLOTS*AW | Value destination register per slot |
| slot_has_dst | input | SLOTS | Slot writes its value destination |
| slot_has_upd | input | SLOTS | Slot also writes back its base register |
| ret_valid | input | RET | Return lane k carries a freed tag |
| ret_tag | input | RET*PW | Freed physical tags |
| tag_src1 | output | SLOTS*PW | Physical tag of the first source |
| tag_src2 | output | SLOTS*PW | Physical tag of the second source |
| tag_dst | output | SLOTS*PW | New tag for the value destination |
| tag_upd | output | SLOTS*PW | New tag for the base update |
| tag_prev_dst | output | SLOTS*PW | Tag displaced by the value destination |
| tag_prev_upd | output | SLOTS*PW | Tag displaced by the base update |
| stall | output | 1 | Group cannot be renamed this cycle |

## Verification
A loop body of a load with base update, an add on the loaded value, a store reading both, and a counter decrement is repeated over several groups. Its fixed tag numbers separate correct allocation order from a swapped order inside a slot, and in-group forwarding from a plain table read. A group where all four slots write one register separates youngest-wins commit from any other choice. Draining the free list, then returning two tags, shows whether the stall threshold is exact, whether a stalled group leaves state untouched, and whether returned tags come back in order. A sweep over all 256 combinations of per-slot destination flags, with pseudo-random register numbers and return traffic, is compared cycle by cycle against an arithmetic model of the map and free list.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int RN_SLOTS = 4;
    localparam int RN_ARCH  = 8;
    localparam int RN_PHYS  = 32;
    localparam int RN_RET   = 2;
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
    parameter  int PHYS   = 32,
    parameter  int ARCH   = 8,
    parameter  int POPS   = 8,
    parameter  int PUSHES = 2,
    localparam int PW     = $clog2(PHYS),
    localparam int CW     = PW + 1,
    localparam int NW     = $clog2(POPS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NW-1:0]        pop_n,
    input  logic [PUSHES-1:0]    push_en,
    input  logic [PUSHES*PW-1:0] push_tag,
    output logic [POPS*PW-1:0]   head_tags,
    output logic [CW-1:0]        free_cnt
);
    logic [PW-1:0] mem [PHYS];
    logic [PW-1:0] head_q, tail_q;
    logic [CW-1:0] cnt_q;
    logic [PW-1:0] push_pos [PUSHES];
    logic [PW-1:0] push_total;

    always_comb begin
        int n;
        n = 0;
        for (int k = 0; k < PUSHES; k++) begin
            push_pos[k] = tail_q + PW'(n);
            if (push_en[k]) n = n + 1;
        end
        push_total = PW'(n);
    end

    always_comb begin
        for (int k = 0; k < POPS; k++)
            head_tags[k*PW +: PW] = mem[head_q + PW'(k)];
    end

    assign free_cnt = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS; i++) begin
                if (i < PHYS - ARCH) mem[i] <= PW'(ARCH + i);
                else                 mem[i] <= '0;
            end
            head_q <= '0;
            tail_q <= PW'(PHYS - ARCH);
            cnt_q  <= CW'(PHYS - ARCH);
        end else begin
            for (int k = 0; k < PUSHES; k++)
                if (push_en[k]) mem[push_pos[k]] <= push_tag[k*PW +: PW];
            head_q <= head_q + PW'(pop_n);
            tail_q <= tail_q + push_total;
            cnt_q  <= cnt_q - CW'(pop_n) + CW'(push_total);
        end
    end

    // R9
    free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(PHYS - ARCH));

    // R8
    pop_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(pop_n) <= cnt_q);
endmodule

// File: rtl/rn_group.sv
module rn_group #(
    parameter  int SLOTS = 4,
    parameter  int ARCH  = 8,
    parameter  int PHYS  = 32,
    localparam int AW    = $clog2(ARCH),
    localparam int PW    = $clog2(PHYS),
    localparam int NW    = $clog2(2*SLOTS + 1)
) (
    input  logic [ARCH*PW-1:0]    map_in,
    input  logic [SLOTS-1:0]      slot_valid,
    input  logic [SLOTS*AW-1:0]   slot_src1,
    input  logic [SLOTS*AW-1:0]   slot_src2,
    input  logic [SLOTS*AW-1:0]   slot_dst,
    input  logic [SLOTS-1:0]      slot_has_dst,
    input  logic [SLOTS-1:0]      slot_has_upd,
    input  logic [2*SLOTS*PW-1:0] free_tags,
    output logic [SLOTS*PW-1:0]   tag_src1,
    output logic [SLOTS*PW-1:0]   tag_src2,
    output logic [SLOTS*PW-1:0]   tag_dst,
    output logic [SLOTS*PW-1:0]   tag_upd,
    output logic [SLOTS*PW-1:0]   tag_prev_dst,
    output logic [SLOTS*PW-1:0]   tag_prev_upd,
    output logic [NW-1:0]         need,
    output logic [ARCH*PW-1:0]    map_out
);
    logic [PW-1:0] cur [ARCH];

    always_comb begin
        int off;
        logic [AW-1:0] a1, a2, ad;
        off = 0;
        for (int r = 0; r < ARCH; r++) cur[r] = map_in[r*PW +: PW];
        tag_dst      = '0;
        tag_upd      = '0;
        tag_prev_dst = '0;
        tag_prev_upd = '0;
        for (int i = 0; i < SLOTS; i++) begin
            a1 = slot_src1[i*AW +: AW];
            a2 = slot_src2[i*AW +: AW];
            ad = slot_dst[i*AW +: AW];
            // sources see every earlier slot's writes, none of this slot's
            tag_src1[i*PW +: PW] = cur[a1];
            tag_src2[i*PW +: PW] = cur[a2];
            if (slot_valid[i] && slot_has_dst[i]) begin
                tag_dst[i*PW +: PW]      = free_tags[off*PW +: PW];
                tag_prev_dst[i*PW +: PW] = cur[ad];
                cur[ad] = free_tags[off*PW +: PW];
                off = off + 1;
            end
            if (slot_valid[i] && slot_has_upd[i]) begin
                tag_upd[i*PW +: PW]      = free_tags[off*PW +: PW];
                tag_prev_upd[i*PW +: PW] = cur[a1];
                cur[a1] = free_tags[off*PW +: PW];
                off = off + 1;
            end
        end
        need = NW'(off);
        for (int r = 0; r < ARCH; r++) map_out[r*PW +: PW] = cur[r];
    end
endmodule

// File: rtl/rename_map4.sv
module rename_map4
    import rn_pkg::*;
#(
    parameter  int SLOTS = RN_SLOTS,
    parameter  int ARCH  = RN_ARCH,
    parameter  int PHYS  = RN_PHYS,
    parameter  int RET   = RN_RET,
    localparam int AW    = $clog2(ARCH),
    localparam int PW    = $clog2(PHYS),
    localparam int CW    = PW + 1,
    localparam int NW    = $clog2(2*SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SLOTS-1:0]     slot_valid,
    input  logic [SLOTS*AW-1:0]  slot_src1,
    input  logic [SLOTS*AW-1:0]  slot_src2,
    input  logic [SLOTS*AW-1:0]  slot_dst,
    input  logic [SLOTS-1:0]     slot_has_dst,
    input  logic [SLOTS-1:0]     slot_has_upd,
    input  logic [RET-1:0]       ret_valid,
    input  logic [RET*PW-1:0]    ret_tag,
    output logic [SLOTS*PW-1:0]  tag_src1,
    output logic [SLOTS*PW-1:0]  tag_src2,
    output logic [SLOTS*PW-1:0]  tag_dst,
    output logic [SLOTS*PW-1:0]  tag_upd,
    output logic [SLOTS*PW-1:0]  tag_prev_dst,
    output logic [SLOTS*PW-1:0]  tag_prev_upd,
    output logic                 stall
);
    logic [PW-1:0]         map_q [ARCH];
    logic [ARCH*PW-1:0]    map_flat, map_next;
    logic [2*SLOTS*PW-1:0] head_tags;
    logic [CW-1:0]         free_cnt;
    logic [NW-1:0]         need, pop_n;

    always_comb begin
        for (int r = 0; r < ARCH; r++) map_flat[r*PW +: PW] = map_q[r];
    end

    rn_freelist #(.PHYS(PHYS), .ARCH(ARCH), .POPS(2*SLOTS), .PUSHES(RET)) u_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop_n     (pop_n),
        .push_en   (ret_valid),
        .push_tag  (ret_tag),
        .head_tags (head_tags),
        .free_cnt  (free_cnt)
    );

    rn_group #(.SLOTS(SLOTS), .ARCH(ARCH), .PHYS(PHYS)) u_grp (
        .map_in       (map_flat),
        .slot_valid   (slot_valid),
        .slot_src1    (slot_src1),
        .slot_src2    (slot_src2),
        .slot_dst     (slot_dst),
        .slot_has_dst (slot_has_dst),
        .slot_has_upd (slot_has_upd),
        .free_tags    (head_tags),
        .tag_src1     (tag_src1),
        .tag_src2     (tag_src2),
        .tag_dst      (tag_dst),
        .tag_upd      (tag_upd),
        .tag_prev_dst (tag_prev_dst),
        .tag_prev_upd (tag_prev_upd),
        .need         (need),
        .map_out      (map_next)
    );

    assign stall = CW'(need) > free_cnt;
    assign pop_n = stall ? '0 : need;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ARCH; r++) map_q[r] <= PW'(r);
        end else if (!stall) begin
            for (int r = 0; r < ARCH; r++) map_q[r] <= map_next[r*PW +: PW];
        end
    end

    // allocation lanes, used only by the checks below
    logic [2*SLOTS-1:0] alloc_en;
    logic [PW-1:0]      alloc_tag [2*SLOTS];
    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            alloc_en[2*i]     = slot_valid[i] && slot_has_dst[i] && !stall;
            alloc_en[2*i+1]   = slot_valid[i] && slot_has_upd[i] && !stall;
            alloc_tag[2*i]    = tag_dst[i*PW +: PW];
            alloc_tag[2*i+1]  = tag_upd[i*PW +: PW];
        end
    end

    for (genvar a = 0; a < 2*SLOTS; a++) begin : g_pa
        for (genvar b = a + 1; b < 2*SLOTS; b++) begin : g_pb
            // R3
            distinct_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (alloc_en[a] && alloc_en[b]) |-> alloc_tag[a] != alloc_tag[b]);
        end
    end

    for (genvar r = 0; r < ARCH; r++) begin : g_hold
        // R8
        map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            stall |=> $stable(map_q[r]));
    end

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && ret_valid == '0) |=> free_cnt == $past(free_cnt) - CW'($past(need)));
endmodule

// File: tb/sim_rename_map4.sv
module sim_rename_map4;
    localparam int SLOTS = 4;
    localparam int ARCH  = 8;
    localparam int PHYS  = 32;
    localparam int RET   = 2;
    localparam int AW    = 3;
    localparam int PW    = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                rst_n;
    logic [SLOTS-1:0]    slot_valid, slot_has_dst, slot_has_upd;
    logic [SLOTS*AW-1:0] slot_src1, slot_src2, slot_dst;
    logic [RET-1:0]      ret_valid;
    logic [RET*PW-1:0]   ret_tag;
    logic [SLOTS*PW-1:0] tag_src1, tag_src2, tag_dst, tag_upd, tag_prev_dst, tag_prev_upd;
    logic                stall;

    rename_map4 u0 (.*);

    int total = 0, bad = 0;
    bit finished = 0;

    int mmap [ARCH];
    int fq [PHYS];
    int fh, ft, fc;
    int pend [PHYS];
    int ph, pt, pc;

    int v [SLOTS], s1 [SLOTS], s2 [SLOTS], d [SLOTS], hd [SLOTS], hu [SLOTS];
    int ret_want;
    int o_s1 [SLOTS], o_s2 [SLOTS], o_dst [SLOTS], o_upd [SLOTS];
    int o_stall;
    bit [31:0] lf = 32'h1234_5678;

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic clear_stim();
        for (int i = 0; i < SLOTS; i++) begin
            v[i] = 0; s1[i] = 0; s2[i] = 0; d[i] = 0; hd[i] = 0; hu[i] = 0;
        end
    endtask

    task automatic model_reset();
        for (int r = 0; r < ARCH; r++) mmap[r] = r;
        for (int i = 0; i < PHYS; i++) fq[i] = (i < PHYS - ARCH) ? ARCH + i : 0;
        fh = 0; ft = PHYS - ARCH; fc = PHYS - ARCH;
        ph = 0; pt = 0; pc = 0;
    endtask

    task automatic step();
        int cur [ARCH];
        int e_s1 [SLOTS], e_s2 [SLOTS], e_d [SLOTS], e_u [SLOTS], e_pd [SLOTS], e_pu [SLOTS];
        int off, nr, es;
        for (int i = 0; i < SLOTS; i++) begin
            slot_valid[i]         = v[i][0];
            slot_has_dst[i]       = hd[i][0];
            slot_has_upd[i]       = hu[i][0];
            slot_src1[i*AW +: AW] = AW'(s1[i]);
            slot_src2[i*AW +: AW] = AW'(s2[i]);
            slot_dst[i*AW +: AW]  = AW'(d[i]);
        end
        nr = ret_want;
        if (nr > pc) nr = pc;
        if (nr > RET) nr = RET;
        for (int k = 0; k < RET; k++) begin
            ret_valid[k] = (k < nr);
            ret_tag[k*PW +: PW] = PW'(pend[(ph + k) % PHYS]);
        end
        for (int r = 0; r < ARCH; r++) cur[r] = mmap[r];
        off = 0;
        for (int i = 0; i < SLOTS; i++) begin
            e_s1[i] = cur[s1[i]];
            e_s2[i] = cur[s2[i]];
            e_d[i] = 0; e_u[i] = 0; e_pd[i] = 0; e_pu[i] = 0;
            if (v[i] != 0 && hd[i] != 0) begin
                e_d[i] = fq[(fh + off) % PHYS]; e_pd[i] = cur[d[i]];
                cur[d[i]] = e_d[i]; off++;
            end
            if (v[i] != 0 && hu[i] != 0) begin
                e_u[i] = fq[(fh + off) % PHYS]; e_pu[i] = cur[s1[i]];
                cur[s1[i]] = e_u[i]; off++;
            end
        end
        es = (off > fc) ? 1 : 0;
        #5;
        o_stall = int'(stall);
        for (int i = 0; i < SLOTS; i++) begin
            o_s1[i]  = int'(tag_src1[i*PW +: PW]);
            o_s2[i]  = int'(tag_src2[i*PW +: PW]);
            o_dst[i] = int'(tag_dst[i*PW +: PW]);
            o_upd[i] = int'(tag_upd[i*PW +: PW]);
        end
        chk(es != 0 ? "R8 stall" : "R1 stall", o_stall, es);
        if (es == 0) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (v[i] != 0) begin
                    chk("R4 src1", o_s1[i], e_s1[i]);
                    chk("R4 src2", o_s2[i], e_s2[i]);
                    if (hd[i] != 0) begin
                        chk("R3 dst", o_dst[i], e_d[i]);
                        chk("R10 prev_dst", int'(tag_prev_dst[i*PW +: PW]), e_pd[i]);
                    end
                    if (hu[i] != 0) begin
                        chk("R2 upd", o_upd[i], e_u[i]);
                        chk("R10 prev_upd", int'(tag_prev_upd[i*PW +: PW]), e_pu[i]);
                    end
                end
            end
        end
        @(posedge clk);
        #1;
        for (int k = 0; k < nr; k++) begin
            fq[ft] = pend[ph];
            ft = (ft + 1) % PHYS; fc++;
            ph = (ph + 1) % PHYS; pc--;
        end
        if (es == 0) begin
            for (int r = 0; r < ARCH; r++) mmap[r] = cur[r];
            fh = (fh + off) % PHYS; fc -= off;
            for (int i = 0; i < SLOTS; i++) begin
                if (v[i] != 0 && hd[i] != 0) begin pend[pt] = e_pd[i]; pt = (pt + 1) % PHYS; pc++; end
                if (v[i] != 0 && hu[i] != 0) begin pend[pt] = e_pu[i]; pt = (pt + 1) % PHYS; pc++; end
            end
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R1 act=0 exp=1");
            finish_run();
        end
    end

    initial begin
        int t3, r0, r1;
        rst_n = 1'b0;
        clear_stim();
        ret_want = 0;
        slot_valid = '0; slot_has_dst = '0; slot_has_upd = '0;
        slot_src1 = '0; slot_src2 = '0; slot_dst = '0;
        ret_valid = '0; ret_tag = '0;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R5: identity map after reset
        for (int i = 0; i < SLOTS; i++) begin v[i] = 1; s1[i] = 2*i; s2[i] = 2*i + 1; end
        step();
        for (int i = 0; i < SLOTS; i++) begin
            chk("R5 reset map src1", o_s1[i], 2*i);
            chk("R5 reset map src2", o_s2[i], 2*i + 1);
        end
        chk("R5 no stall after reset", o_stall, 0);

        // loop body: load+update r1<-[r3], add r1, store r1/r3, decrement r7
        for (int it = 0; it < 4; it++) begin
            clear_stim();
            v[0] = 1; s1[0] = 3; d[0] = 1; hd[0] = 1; hu[0] = 1;
            v[1] = 1; s1[1] = 1; d[1] = 1; hd[1] = 1;
            v[2] = 1; s1[2] = 1; s2[2] = 3;
            v[3] = 1; s1[3] = 7; d[3] = 7; hd[3] = 1;
            step();
            if (it == 0) begin
                chk("R5 first tag", o_dst[0], 8);
                chk("R6 upd after dst", o_upd[0], 9);
                chk("R2 old base read", o_s1[0], 3);
                chk("R4 bypass slot1", o_s1[1], 8);
                chk("R6 slot1 dst", o_dst[1], 10);
                chk("R4 bypass value", o_s1[2], 10);
                chk("R4 bypass base", o_s2[2], 9);
                chk("R6 slot3 dst", o_dst[3], 11);
            end
        end

        // R7: four writers of r5
        clear_stim();
        for (int i = 0; i < SLOTS; i++) begin v[i] = 1; d[i] = 5; hd[i] = 1; end
        s1[1] = 5;
        step();
        t3 = o_dst[3];
        chk("R4 same-arch bypass", o_s1[1], o_dst[0]);
        clear_stim();
        v[0] = 1; s1[0] = 5;
        step();
        chk("R7 youngest commit", o_s1[0], t3);

        // R8: group needing more than remain (4 free)
        clear_stim();
        for (int i = 0; i < SLOTS; i++) begin v[i] = 1; d[i] = 5; hd[i] = 1; hu[i] = 1; s1[i] = 6; end
        step();
        chk("R8 stall on shortage", o_stall, 1);
        step();
        chk("R8 stall repeats", o_stall, 1);
        clear_stim();
        v[0] = 1; s1[0] = 5; s2[0] = 6;
        step();
        chk("R8 map untouched", o_s1[0], t3);
        chk("R8 map untouched r6", o_s2[0], mmap[6]);
        clear_stim();
        for (int i = 0; i < 2; i++) begin v[i] = 1; d[i] = 2; hd[i] = 1; hu[i] = 1; s1[i] = 4; end
        step();
        chk("R8 exact fit", o_stall, 0);
        clear_stim();
        v[0] = 1; d[0] = 2; hd[0] = 1;
        step();
        chk("R8 empty list stalls", o_stall, 1);

        // R9: returned tags reused in order
        r0 = pend[ph]; r1 = pend[(ph + 1) % PHYS];
        clear_stim();
        ret_want = 2;
        step();
        ret_want = 0;
        v[0] = 1; d[0] = 0; hd[0] = 1; hu[0] = 1; s1[0] = 3;
        step();
        chk("R9 first returned", o_dst[0], r0);
        chk("R9 second returned", o_upd[0], r1);

        // sweep over all per-slot destination-flag combinations
        for (int rep = 0; rep < 6; rep++) begin
            for (int pat = 0; pat < 256; pat++) begin
                clear_stim();
                for (int i = 0; i < SLOTS; i++) begin
                    lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                    v[i]  = (lf[15:13] != 3'd0) ? 1 : 0;
                    s1[i] = int'(lf[2:0]);
                    s2[i] = int'(lf[5:3]);
                    d[i]  = int'(lf[8:6]);
                    hd[i] = (pat >> (2*i)) & 1;
                    hu[i] = (pat >> (2*i + 1)) & 1;
                end
                ret_want = int'(lf[20:19]) % 3;
                if (rep == 0) ret_want = 2;
                step();
            end
        end

        finish_run();
    end
endmodule